// File: doc/BRIEF.md
# Flash Program/Erase Engine with Boot-Sector Lockout

This block accepts byte-program, sector-erase and whole-array-erase requests and carries them out on a scaled-down, synthesizable byte array. Each accepted request raises a busy flag for a fixed number of clock cycles that stands in for the internally timed operation. At the end of that window the change lands in the array and the engine falls back to the read state by itself. Programming can only clear bits. Erasing sets bytes to 0xFF.

The array is split into five sectors of unequal size: two main sectors, two small parameter sectors and a boot sector at the top of the address space. A sticky lockout flag protects the boot sector from programs and erases, including the whole-array erase. A level input suspends the lockout for as long as it is held. The host reads the array through a registered read port. It can see the address and data of the last accepted request.

Top module: `flash_pe_engine`

## Requirements
- R1: The address space of 2^ADDR_W bytes is cut into 32 equal units numbered by the top five address bits. Units 0-15 form the low main sector, units 16-27 the high main sector, unit 28 parameter sector A, unit 29 parameter sector B and units 30-31 the boot sector.
- R2: A program stores the bitwise AND of the old byte and the new data at the addressed byte, so bits only go from 1 to 0.
- R3: A sector erase sets every byte of the sector that holds the request address to 0xFF and leaves all other bytes alone. A sector erase aimed at the boot sector changes nothing.
- R4: A whole-array erase sets every byte to 0xFF while the lockout is not in force. While the lockout is in force, it erases the four non-boot sectors and leaves the boot sector unchanged.
- R5: A pulse on `lock_req` sets the lockout. From then on, programs aimed at the boot sector have no effect, while the other sectors stay writable.
- R6: A request accepted while `hv_override` is 1 ignores the lockout. A request accepted after `hv_override` returns to 0 is blocked again.
- R7: `busy` is 1 from the cycle after a request is accepted for exactly PROG_CYCLES cycles for a program, or ERASE_CYCLES cycles for either erase, even when the write is blocked. The array change appears at the clock edge where `busy` falls, and the engine then accepts requests again without any host action.
- R8: Requests that arrive while `busy` is 1 are ignored. They change neither the array nor `last_addr` or `last_data`.
- R9: `rst_n` low at a clock edge clears `busy`, the lockout, `last_addr`, `last_data` and `rd_data`. An operation in progress is dropped without touching the array.
- R10: On acceptance, `last_addr` takes the request address. `last_data` takes the program data for a program, or 0xFF for either erase.
- R11: When several strobes are high in the cycle of acceptance, whole-array erase wins over sector erase, and sector erase wins over program.
- R12: `rd_data` shows the byte at `rd_addr` one clock cycle after `rd_addr` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_req | input | 1 | Program strobe |
| sect_erase_req | input | 1 | Sector-erase strobe |
| chip_erase_req | input | 1 | Whole-array erase strobe |
| lock_req | input | 1 | Sets the boot-sector lockout |
| hv_override | input | 1 | Level that suspends the lockout while 1 |
| addr | input | ADDR_W | Request address |
| wdata | input | 8 | Program data |
| rd_addr | input | ADDR_W | Read-port address |
| busy | output | 1 | Operation in progress |
| last_addr | output | ADDR_W | Address of the last accepted request |
| last_data | output | 8 | Data of the last accepted request |
| rd_data | output | 8 | Registered read data |

## Verification
The bench builds the engine with ADDR_W = 8, PROG_CYCLES = 5 and ERASE_CYCLES = 12. This gives a 256-byte array with 8-byte units. With that size, every sector boundary can be probed byte by byte, and the whole array can be swept after each erase. The short durations leave room for many random operations in the cycle budget. The durations still differ enough that a program window cannot be mistaken for an erase window, and the bench can place requests and a reset in the middle of a running window.

// File: rtl/fpe_pkg.sv
// Package: shared types and the fixed sector map of the program/erase engine.
// Assumes the array is cut into 32 equal units addressed by the top five
// address bits.
package fpe_pkg;

    localparam int MAP_UNIT_BITS = 5;
    localparam int NUM_SECTORS   = 5;

    typedef enum logic [2:0] {
        SEC_MAIN_LO = 3'd0,
        SEC_MAIN_HI = 3'd1,
        SEC_PARAM_A = 3'd2,
        SEC_PARAM_B = 3'd3,
        SEC_BOOT    = 3'd4
    } sector_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2
    } op_e;

    // Map a unit index (top five address bits) to its sector.
    function automatic sector_e sector_of(input logic [MAP_UNIT_BITS-1:0] unit_idx);
        if (unit_idx < 5'd16)       return SEC_MAIN_LO;
        else if (unit_idx < 5'd28)  return SEC_MAIN_HI;
        else if (unit_idx == 5'd28) return SEC_PARAM_A;
        else if (unit_idx == 5'd29) return SEC_PARAM_B;
        else                        return SEC_BOOT;
    endfunction

endpackage

// File: rtl/fpe_req_ctrl.sv
// Request control: picks one request by priority while idle, applies the
// lockout and override rules at acceptance, and latches the resulting
// operation (kind, address, data, sector erase mask) until the commit.
// Assumes the busy input comes from the timer that this block starts.
module fpe_req_ctrl #(
    parameter int ADDR_W = 10
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                prog_req,
    input  logic                                sect_erase_req,
    input  logic                                chip_erase_req,
    input  logic                                lock_req,
    input  logic                                hv_override,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [7:0]                          wdata,
    input  logic                                busy,
    output logic                                start,
    output logic                                start_erase,
    output fpe_pkg::op_e                        op_kind,
    output logic [ADDR_W-1:0]                   op_addr,
    output logic [7:0]                          op_data,
    output logic [fpe_pkg::NUM_SECTORS-1:0]     erase_mask,
    output logic [ADDR_W-1:0]                   last_addr,
    output logic [7:0]                          last_data
);
    import fpe_pkg::*;

    logic                     lock_q;
    logic                     eff_lock;
    logic                     any_req;
    sector_e                  req_sec;
    op_e                      nxt_kind;
    logic [NUM_SECTORS-1:0]   nxt_mask;
    logic                     nxt_erase;

    assign any_req  = prog_req | sect_erase_req | chip_erase_req;
    assign start    = any_req & ~busy;
    assign eff_lock = lock_q & ~hv_override;
    assign req_sec  = sector_of(addr[ADDR_W-1 -: MAP_UNIT_BITS]);
    assign start_erase = start & nxt_erase;

    // Decode the winning request and its effective target set.
    always_comb begin
        nxt_kind  = OP_NONE;
        nxt_mask  = '0;
        nxt_erase = 1'b0;
        if (chip_erase_req) begin
            nxt_kind  = OP_ERASE;
            nxt_erase = 1'b1;
            nxt_mask  = '1;
            if (eff_lock) begin
                nxt_mask[SEC_BOOT] = 1'b0;
            end
        end else if (sect_erase_req) begin
            nxt_kind  = OP_ERASE;
            nxt_erase = 1'b1;
            if (req_sec != SEC_BOOT) begin
                nxt_mask[req_sec] = 1'b1;
            end
        end else if (prog_req) begin
            if (req_sec == SEC_BOOT && eff_lock) begin
                nxt_kind = OP_NONE;
            end else begin
                nxt_kind = OP_PROG;
            end
        end
    end

    // Sticky lockout flag, set by a request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
        end else if (lock_req) begin
            lock_q <= 1'b1;
        end
    end

    // Latch the accepted operation and the last-request record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_kind    <= OP_NONE;
            op_addr    <= '0;
            op_data    <= '0;
            erase_mask <= '0;
            last_addr  <= '0;
            last_data  <= '0;
        end else if (start) begin
            op_kind    <= nxt_kind;
            op_addr    <= addr;
            op_data    <= wdata;
            erase_mask <= nxt_mask;
            last_addr  <= addr;
            last_data  <= nxt_erase ? 8'hFF : wdata;
        end
    end

endmodule

// File: rtl/fpe_busy_timer.sv
// Busy timer: holds busy for a program or erase duration counted in clock
// cycles and pulses done in the last busy cycle. Assumes both durations are
// at least one cycle and that start is only given while idle.
module fpe_busy_timer #(
    parameter int PROG_CYCLES  = 4,
    parameter int ERASE_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic start_erase,
    output logic busy,
    output logic done
);
    localparam int MAX_CYC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    logic [CNT_W-1:0] remain_q;

    assign done = rst_n & busy & (remain_q == '0);

    // Load the duration on start, then count down to the final busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            remain_q <= '0;
        end else if (start) begin
            busy     <= 1'b1;
            remain_q <= start_erase ? CNT_W'(ERASE_CYCLES - 1) : CNT_W'(PROG_CYCLES - 1);
        end else if (busy) begin
            if (remain_q == '0) begin
                busy <= 1'b0;
            end else begin
                remain_q <= remain_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/fpe_byte_array.sv
// Byte array: one register per byte, each knowing its own sector. It applies
// the latched operation when commit is high and serves a registered read
// port. Assumes the array contents are not reset (they stand for
// non-volatile cells).
module fpe_byte_array #(
    parameter int ADDR_W = 10
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                commit,
    input  fpe_pkg::op_e                        op_kind,
    input  logic [ADDR_W-1:0]                   op_addr,
    input  logic [7:0]                          op_data,
    input  logic [fpe_pkg::NUM_SECTORS-1:0]     erase_mask,
    input  logic [ADDR_W-1:0]                   rd_addr,
    output logic [7:0]                          rd_data
);
    import fpe_pkg::*;

    localparam int DEPTH      = 1 << ADDR_W;
    localparam int UNIT_SHIFT = ADDR_W - MAP_UNIT_BITS;

    logic [DEPTH-1:0][7:0] cells;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        localparam sector_e CELL_SEC = sector_of(MAP_UNIT_BITS'(i >> UNIT_SHIFT));
        logic [7:0] cell_q;

        // Apply a program (AND) or an erase (all ones) to this byte.
        always_ff @(posedge clk) begin
            if (commit) begin
                if (op_kind == OP_PROG && op_addr == ADDR_W'(i)) begin
                    cell_q <= cell_q & op_data;
                end else if (op_kind == OP_ERASE && erase_mask[CELL_SEC]) begin
                    cell_q <= 8'hFF;
                end
            end
        end

        assign cells[i] = cell_q;
    end

    // Registered read of the addressed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= cells[rd_addr];
        end
    end

endmodule

// File: rtl/flash_pe_engine.sv
// Top of the program/erase engine: request control, busy timer and byte
// array. Assumes ADDR_W >= 5 so that the 32-unit sector map fits.
module flash_pe_engine #(
    parameter int ADDR_W       = 10,
    parameter int PROG_CYCLES  = 4,
    parameter int ERASE_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_req,
    input  logic              sect_erase_req,
    input  logic              chip_erase_req,
    input  logic              lock_req,
    input  logic              hv_override,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              busy,
    output logic [ADDR_W-1:0] last_addr,
    output logic [7:0]        last_data,
    output logic [7:0]        rd_data
);
    import fpe_pkg::*;

    logic                   start;
    logic                   start_erase;
    logic                   done;
    op_e                    op_kind;
    logic [ADDR_W-1:0]      op_addr;
    logic [7:0]             op_data;
    logic [NUM_SECTORS-1:0] erase_mask;

    fpe_req_ctrl #(
        .ADDR_W (ADDR_W)
    ) i_req_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .prog_req       (prog_req),
        .sect_erase_req (sect_erase_req),
        .chip_erase_req (chip_erase_req),
        .lock_req       (lock_req),
        .hv_override    (hv_override),
        .addr           (addr),
        .wdata          (wdata),
        .busy           (busy),
        .start          (start),
        .start_erase    (start_erase),
        .op_kind        (op_kind),
        .op_addr        (op_addr),
        .op_data        (op_data),
        .erase_mask     (erase_mask),
        .last_addr      (last_addr),
        .last_data      (last_data)
    );

    fpe_busy_timer #(
        .PROG_CYCLES  (PROG_CYCLES),
        .ERASE_CYCLES (ERASE_CYCLES)
    ) i_busy_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_erase (start_erase),
        .busy        (busy),
        .done        (done)
    );

    fpe_byte_array #(
        .ADDR_W (ADDR_W)
    ) i_byte_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (done),
        .op_kind    (op_kind),
        .op_addr    (op_addr),
        .op_data    (op_data),
        .erase_mask (erase_mask),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data)
    );

endmodule

// File: rtl/fpe_checker.sv
// Checker: temporal properties of the engine's ports, attached by bind.
// Tracks the expected busy window with counters rather than long delays.
module fpe_checker #(
    parameter int ADDR_W       = 10,
    parameter int PROG_CYCLES  = 4,
    parameter int ERASE_CYCLES = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              prog_req,
    input logic              sect_erase_req,
    input logic              chip_erase_req,
    input logic              busy,
    input logic [ADDR_W-1:0] last_addr,
    input logic [7:0]        last_data
);
    logic any_req;
    int   run_len;
    int   exp_len;

    assign any_req = prog_req | sect_erase_req | chip_erase_req;

    // Count busy cycles since acceptance and remember the expected length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= 0;
            exp_len <= 0;
        end else if (!busy && any_req) begin
            run_len <= 1;
            exp_len <= (sect_erase_req || chip_erase_req) ? ERASE_CYCLES : PROG_CYCLES;
        end else if (busy) begin
            run_len <= run_len + 1;
        end
    end

    AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && any_req) |=> busy);  // R7
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && run_len < exp_len) |=> busy);  // R7
    AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && run_len == exp_len) |=> !busy);  // R7
    AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(last_addr) && $stable(last_data)));  // R8
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> !busy);  // R9
    AST_ERASE_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (sect_erase_req || chip_erase_req)) |=> (last_data == 8'hFF));  // R10

endmodule

bind flash_pe_engine fpe_checker #(
    .ADDR_W       (ADDR_W),
    .PROG_CYCLES  (PROG_CYCLES),
    .ERASE_CYCLES (ERASE_CYCLES)
) i_fpe_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .prog_req       (prog_req),
    .sect_erase_req (sect_erase_req),
    .chip_erase_req (chip_erase_req),
    .busy           (busy),
    .last_addr      (last_addr),
    .last_data      (last_data)
);

// File: tb/test_flash_pe_engine.sv
// Bench: directed corner cases plus seeded random operations, checked
// against a byte-array model kept in the bench.
module test_flash_pe_engine;
    localparam int AW    = 8;
    localparam int PCYC  = 5;
    localparam int ECYC  = 12;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prog_req = 1'b0;
    logic          sect_erase_req = 1'b0;
    logic          chip_erase_req = 1'b0;
    logic          lock_req = 1'b0;
    logic          hv_override = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [AW-1:0] rd_addr = '0;
    logic          busy;
    logic [AW-1:0] last_addr;
    logic [7:0]    last_data;
    logic [7:0]    rd_data;

    int         checks = 0;
    int         errors = 0;
    logic [7:0] model [DEPTH];
    bit         locked = 0;

    always #2.5 clk = ~clk;

    flash_pe_engine #(
        .ADDR_W (AW), .PROG_CYCLES (PCYC), .ERASE_CYCLES (ECYC)
    ) i_flash_pe_engine (
        .clk (clk), .rst_n (rst_n), .prog_req (prog_req),
        .sect_erase_req (sect_erase_req), .chip_erase_req (chip_erase_req),
        .lock_req (lock_req), .hv_override (hv_override), .addr (addr),
        .wdata (wdata), .rd_addr (rd_addr), .busy (busy),
        .last_addr (last_addr), .last_data (last_data), .rd_data (rd_data)
    );

    // Sector of a byte for the 256-byte map: 0 low main, 1 high main,
    // 2 parameter A, 3 parameter B, 4 boot.
    function automatic int bsec(input int a);
        if (a < 'h80)      return 0;
        else if (a < 'hE0) return 1;
        else if (a < 'hE8) return 2;
        else if (a < 'hF0) return 3;
        else               return 4;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Update the model with the effect a request should have.
    task automatic model_apply(input bit p, input bit se, input bit ce,
                               input int a, input logic [7:0] d, input bit hv);
        bit eff;
        eff = locked && !hv;
        if (ce) begin
            for (int i = 0; i < DEPTH; i++)
                if (!(eff && bsec(i) == 4)) model[i] = 8'hFF;
        end else if (se) begin
            if (bsec(a) != 4)
                for (int i = 0; i < DEPTH; i++)
                    if (bsec(i) == bsec(a)) model[i] = 8'hFF;
        end else if (p) begin
            if (!(eff && bsec(a) == 4)) model[a] = model[a] & d;
        end
    endtask

    task automatic read_chk(input int a, input string req);
        @(negedge clk);
        rd_addr = AW'(a);
        @(posedge clk);
        @(negedge clk);
        chk(rd_data == model[a], req, $sformatf("byte %0h", a), rd_data, model[a]);
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < DEPTH; i++) read_chk(i, req);
    endtask

    // Issue one request, wait out busy, check duration, record and target byte.
    task automatic run_op(input bit p, input bit se, input bit ce, input int a,
                          input logic [7:0] d, input bit hv, input string req);
        int len;
        int exp_len;
        @(negedge clk);
        prog_req = p; sect_erase_req = se; chip_erase_req = ce;
        addr = AW'(a); wdata = d; hv_override = hv;
        @(posedge clk);
        @(negedge clk);
        prog_req = 0; sect_erase_req = 0; chip_erase_req = 0; hv_override = 0;
        model_apply(p, se, ce, a, d, hv);
        len = 0;
        while (busy && len < 1000) begin
            len++;
            @(negedge clk);
        end
        exp_len = (se || ce) ? ECYC : PCYC;
        chk(len == exp_len, "R7", "busy length", len, exp_len);
        chk(last_addr == AW'(a), "R10", "last_addr", last_addr, a);
        chk(last_data == ((se || ce) ? 8'hFF : d), "R10", "last_data",
            last_data, (se || ce) ? 8'hFF : d);
        read_chk(a, req);
    endtask

    task automatic pulse_lock();
        @(negedge clk);
        lock_req = 1;
        @(negedge clk);
        lock_req = 0;
        locked = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int a;
        int kind;
        int len;
        logic [7:0] d;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R9 reset state
        chk(busy == 0, "R9", "busy after reset", busy, 0);
        chk(last_addr == 0, "R9", "last_addr after reset", last_addr, 0);
        chk(last_data == 0, "R9", "last_data after reset", last_data, 0);

        // R4: whole-array erase without lockout
        run_op(0, 0, 1, 'h33, 8'h00, 0, "R4");
        check_all("R4");

        // R2: program only clears bits
        run_op(1, 0, 0, 'h10, 8'hA5, 0, "R2");
        run_op(1, 0, 0, 'h10, 8'h3C, 0, "R2");
        read_chk('h10, "R2 R12");

        // Fill every sector near its edges
        for (int i = 0; i < 16; i++) begin
            a = (i < 8) ? ('h7C + i) : ('hDC + (i - 8) * 3);
            run_op(1, 0, 0, a, 8'h00, 0, "R2");
        end
        run_op(1, 0, 0, 'hF0, 8'h12, 0, "R2");
        run_op(1, 0, 0, 'hFF, 8'h34, 0, "R2");

        // R1 R3: sector erase of parameter A only
        run_op(0, 1, 0, 'hE3, 8'h00, 0, "R3");
        check_all("R1 R3");
        // R3: sector erase aimed at boot changes nothing
        run_op(0, 1, 0, 'hF5, 8'h00, 0, "R3");
        check_all("R3");

        // R5: lockout blocks boot programs, others stay writable
        pulse_lock();
        run_op(1, 0, 0, 'hF8, 8'h0F, 0, "R5");
        run_op(1, 0, 0, 'h20, 8'h0F, 0, "R5");

        // R4: whole-array erase with lockout keeps boot
        run_op(0, 0, 1, 'h00, 8'h00, 0, "R4");
        check_all("R4");

        // R6: override lets a boot program through, removal restores lockout
        run_op(1, 0, 0, 'hF9, 8'h5A, 1, "R6");
        run_op(1, 0, 0, 'hFA, 8'h5A, 0, "R6");
        run_op(0, 0, 1, 'h00, 8'h00, 1, "R6");
        check_all("R6");

        // R8: a request during busy is ignored
        @(negedge clk);
        prog_req = 1; addr = 8'h40; wdata = 8'h11;
        @(posedge clk);
        @(negedge clk);
        model_apply(1, 0, 0, 'h40, 8'h11, 0);
        addr = 8'h41; wdata = 8'h00;
        @(negedge clk);
        sect_erase_req = 1; addr = 8'h90;
        @(negedge clk);
        prog_req = 0; sect_erase_req = 0;
        chk(last_addr == 8'h40, "R8", "last_addr during busy", last_addr, 'h40);
        len = 3;
        while (busy && len < 1000) begin
            len++;
            @(negedge clk);
        end
        chk(len == PCYC + 1, "R8", "busy with extra requests", len, PCYC + 1);
        chk(last_data == 8'h11, "R8", "last_data after busy", last_data, 'h11);
        read_chk('h40, "R8");
        read_chk('h41, "R8");
        read_chk('h90, "R8");

        // R11: priority among simultaneous strobes
        run_op(1, 1, 1, 'h05, 8'h00, 0, "R11");
        check_all("R11");
        run_op(1, 0, 0, 'h85, 8'h00, 0, "R11");
        run_op(1, 1, 0, 'h85, 8'h00, 0, "R11");
        read_chk('h80, "R11");

        // R9: reset in mid-operation drops the write and the lockout
        @(negedge clk);
        prog_req = 1; addr = 8'h60; wdata = 8'h00;
        @(posedge clk);
        @(negedge clk);
        prog_req = 0;
        @(negedge clk);
        rst_n = 0;
        @(posedge clk);
        @(negedge clk);
        chk(busy == 0, "R9", "busy after abort", busy, 0);
        chk(last_addr == 0, "R9", "last_addr after abort", last_addr, 0);
        rst_n = 1;
        locked = 0;
        repeat (PCYC + 2) @(negedge clk);
        read_chk('h60, "R9");
        run_op(1, 0, 0, 'hF1, 8'h0F, 0, "R9");

        // Random operations against the model
        for (int n = 0; n < 80; n++) begin
            kind = $urandom % 16;
            a = $urandom % DEPTH;
            d = 8'($urandom);
            if (kind == 0) pulse_lock();
            if (kind < 10)
                run_op(1, 0, 0, a, d, ($urandom % 4) == 0, "R2");
            else if (kind < 15)
                run_op(0, 1, 0, a, d, ($urandom % 4) == 0, "R3");
            else
                run_op(0, 0, 1, a, d, ($urandom % 4) == 0, "R4");
            for (int k = 0; k < 3; k++) read_chk($urandom % DEPTH, "R1");
        end
        check_all("R1");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule